// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a global record of the outcomes of the most recent branches. Each address-selected row of its counter table holds one saturating counter for every possible value of that record. A lookup port takes the fetch address and answers in the same cycle. It also hands back the history value it used, and the pipeline carries that value along with the branch. When the branch resolves, an update port returns the branch address, the real outcome and that saved history. The counter that made the prediction is trained, and the outcome enters the global history.

Three parameters set the shape: `HIST_BITS` is the history length, `CTR_BITS` is the counter width and `IDX_BITS` is log2 of the number of address rows. The storage is 2^(HIST_BITS+IDX_BITS) counters of `CTR_BITS` bits. With `HIST_BITS` = 0 the block is a plain address-indexed counter table. With `IDX_BITS` = 0 the address is ignored and only the history chooses the counter.

For a 2-bit counter the four states are strong not-taken (00), weak not-taken (01), weak taken (10) and strong taken (11). A taken outcome moves one state toward strong taken and a not-taken outcome moves one state toward strong not-taken. A counter never moves past either end. The defaults used below are `HIST_BITS` = 2, `CTR_BITS` = 2 and `IDX_BITS` = 4.

Top module: `bp_corr_predictor`

## Requirements
- R1: After reset, every counter holds the weak not-taken value 2^(CTR_BITS-1)-1 (01 for 2 bits) and the history is zero. So `lk_taken` is 0 for every address and `lk_hist` is 0.
- R2: `lk_taken` is the top bit of the counter at index {pc[IDX_BITS+1:2], history}, with the address bits high and the history bits low. It responds combinationally in the same cycle as `lk_pc`.
- R3: An update with `up_taken`=1 adds one to the selected counter. A counter already at all ones stays there.
- R4: An update with `up_taken`=0 subtracts one from the selected counter. A counter already at zero stays there.
- R5: Each cycle with `up_valid`=1 shifts `up_taken` into history bit 0. The older bits move one place toward the MSB and the oldest bit is dropped. `lk_hist` shows the current history. With `up_valid`=0 the history does not change.
- R6: An update selects its counter with `up_hist` and not with the current global history.
- R7: PC bits 1:0 and the PC bits above bit IDX_BITS+1 play no part in choosing a counter. Addresses that differ only in those bits share counters.
- R8: When a lookup and an update select the same counter in the same cycle, `lk_taken` reflects the counter value from before the update.
- R9: The counters for different history values under one address are independent. Training one of them leaves the prediction of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Prediction: 1 taken, 0 not taken |
| lk_hist | output | max(HIST_BITS,1) | History used for this lookup, kept by the pipeline |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| up_hist | input | max(HIST_BITS,1) | History snapshot saved at prediction time |

## Verification
The assertions check two things on every cycle. First, the history moves only on an update, and then by exactly one bit. Second, a written counter ends exactly one step from its previous value, or stays put at either end. The bench drives random addresses, outcomes and snapshots against a reference model of the table. Only those scenarios can show that the right counter was chosen: that snapshots are honoured over the live history, that addresses alias, that a lookup colliding with an update reads the old value, and that the counters under one address stay independent of each other.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    // One saturating step of a direction counter
    function automatic int sat_step(input int val, input bit up, input int maxv);
        if (up)
            return (val >= maxv) ? maxv : val + 1;
        else
            return (val <= 0) ? 0 : val - 1;
    endfunction

endpackage

// File: rtl/bp_hist_reg.sv
`timescale 1ns/1ps
module bp_hist_reg #(
    parameter int HIST_BITS = 2,
    localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_in,
    output logic [HW-1:0] hist_o
);

    logic [HW-1:0] hist_q;

    generate
        if (HIST_BITS > 0) begin : g_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    hist_q <= '0;
                else if (shift_en)
                    hist_q <= HW'({hist_q, shift_in});
            end

            // R5
            hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_o[0] == $past(shift_in));
            // R5
            hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !shift_en |=> $stable(hist_o));

            if (HIST_BITS > 1) begin : g_age
                // R5
                hist_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    shift_en |=> hist_o[HW-1:1] == $past(hist_o[HW-2:0]));
            end
        end else begin : g_none
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    hist_q <= '0;
                else
                    hist_q <= '0;
            end
        end
    endgenerate

    assign hist_o = hist_q;

endmodule

// File: rtl/bp_index.sv
`timescale 1ns/1ps
module bp_index #(
    parameter int PC_W      = 32,
    parameter int IDX_BITS  = 4,
    parameter int HIST_BITS = 2,
    localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int AW = IDX_BITS + HIST_BITS
) (
    input  logic [PC_W-1:0] pc,
    input  logic [HW-1:0]   hist,
    output logic [AW-1:0]   idx
);

    localparam logic [63:0] ROW_MASK  = (64'd1 << IDX_BITS) - 64'd1;
    localparam logic [63:0] HIST_MASK = (64'd1 << HIST_BITS) - 64'd1;

    logic [63:0] row;
    logic [63:0] hsel;

    always_comb begin
        row  = (64'(pc) >> 2) & ROW_MASK;
        hsel = 64'(hist) & HIST_MASK;
        idx  = AW'((row << HIST_BITS) | hsel);
    end

endmodule

// File: rtl/bp_ctr_table.sv
`timescale 1ns/1ps
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int AW       = 6,
    parameter int CTR_BITS = 2,
    localparam int DEPTH = 1 << AW,
    localparam int MAXV  = (1 << CTR_BITS) - 1,
    localparam int INITV = (1 << (CTR_BITS - 1)) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       rd_idx,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_idx,
    input  logic                wr_up
);

    logic [CTR_BITS-1:0] ctr_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                ctr_q[i] <= CTR_BITS'(INITV);
        end else if (wr_en) begin
            ctr_q[wr_idx] <= CTR_BITS'(sat_step(int'(ctr_q[wr_idx]), wr_up, MAXV));
        end
    end

    // read sees pre-write contents (R8)
    assign rd_ctr = ctr_q[rd_idx];

    // checker state: last write and the value it replaced
    logic                chk_v;
    logic                chk_up;
    logic [AW-1:0]       chk_idx;
    logic [CTR_BITS-1:0] chk_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_v   <= 1'b0;
            chk_up  <= 1'b0;
            chk_idx <= '0;
            chk_old <= '0;
        end else begin
            chk_v   <= wr_en;
            chk_up  <= wr_up;
            chk_idx <= wr_idx;
            chk_old <= ctr_q[wr_idx];
        end
    end

    // R3
    ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_v && chk_up) |->
            ctr_q[chk_idx] == ((int'(chk_old) == MAXV) ? chk_old : chk_old + 1'b1));
    // R4
    ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_v && !chk_up) |->
            ctr_q[chk_idx] == ((chk_old == '0) ? chk_old : chk_old - 1'b1));

endmodule

// File: rtl/bp_corr_predictor.sv
`timescale 1ns/1ps
module bp_corr_predictor #(
    parameter int PC_W      = 32,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2,
    parameter int IDX_BITS  = 4,
    localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int AW = IDX_BITS + HIST_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic [HW-1:0]   lk_hist,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [HW-1:0]   up_hist
);

    logic [HW-1:0]       ghist;
    logic [AW-1:0]       rd_idx;
    logic [AW-1:0]       wr_idx;
    logic [CTR_BITS-1:0] rd_ctr;

    bp_hist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .shift_in (up_taken),
        .hist_o   (ghist)
    );

    bp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_rd_index (
        .pc   (lk_pc),
        .hist (ghist),
        .idx  (rd_idx)
    );

    // R6: training uses the snapshot, not the live history
    bp_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_wr_index (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (wr_idx)
    );

    bp_ctr_table #(.AW(AW), .CTR_BITS(CTR_BITS)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_ctr (rd_ctr),
        .wr_en  (up_valid),
        .wr_idx (wr_idx),
        .wr_up  (up_taken)
    );

    assign lk_taken = rd_ctr[CTR_BITS-1];
    assign lk_hist  = ghist;

endmodule

// File: tb/bp_corr_predictor_tb_top.sv
`timescale 1ns/1ps
module bp_corr_predictor_tb_top;

    localparam int PW    = 32;
    localparam int M     = 2;
    localparam int N     = 2;
    localparam int IB    = 4;
    localparam int HW    = (M > 0) ? M : 1;
    localparam int ENT   = 1 << IB;
    localparam int TBL   = ENT << M;
    localparam int MAXV  = (1 << N) - 1;
    localparam int INITV = (1 << (N - 1)) - 1;
    localparam logic [31:0] DUMMY_PC = 32'h0000_0008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] lk_pc = '0;
    logic          lk_taken;
    logic [HW-1:0] lk_hist;
    logic          up_valid = 1'b0;
    logic [PW-1:0] up_pc = '0;
    logic          up_taken = 1'b0;
    logic [HW-1:0] up_hist = '0;

    int mdl [TBL];
    int mhist;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bp_corr_predictor #(.PC_W(PW), .HIST_BITS(M), .CTR_BITS(N), .IDX_BITS(IB)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .lk_hist  (lk_hist),
        .up_valid (up_valid),
        .up_pc    (up_pc),
        .up_taken (up_taken),
        .up_hist  (up_hist)
    );

    function automatic int midx(input logic [31:0] pc, input int h);
        return (int'((pc >> 2) & (ENT - 1)) << M) | (h & ((1 << M) - 1));
    endfunction

    function automatic int mpred(input logic [31:0] pc);
        return (mdl[midx(pc, mhist)] >> (N - 1)) & 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before the edge, then advance the model
    task automatic cycle(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                         input bit ut, input int uh, input string tag);
        @(negedge clk);
        lk_pc    = lpc;
        up_valid = uv;
        up_pc    = upc;
        up_taken = ut;
        up_hist  = HW'(uh);
        #1;
        check(tag, int'(lk_taken), mpred(lpc));
        check("R5", int'(lk_hist), mhist);
        @(posedge clk);
        if (uv) begin
            int k;
            k = midx(upc, uh);
            if (ut) mdl[k] = (mdl[k] >= MAXV) ? MAXV : mdl[k] + 1;
            else    mdl[k] = (mdl[k] <= 0) ? 0 : mdl[k] - 1;
            mhist = ((mhist << 1) | int'(ut)) & ((1 << M) - 1);
        end
    endtask

    task automatic set_hist(input int h);
        for (int i = 0; i < M; i++)
            cycle(32'h0, 1'b1, DUMMY_PC, bit'((h >> (M - 1 - i)) & 1), 0, "R5");
    endtask

    task automatic probe(input logic [31:0] pc, input string tag, input int exp_taken);
        @(negedge clk);
        lk_pc    = pc;
        up_valid = 1'b0;
        #1;
        check(tag, int'(lk_taken), exp_taken);
        check(tag, int'(lk_taken), mpred(pc));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < TBL; i++) mdl[i] = INITV;
        mhist = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the lookup port
        for (int i = 0; i < ENT; i++) begin
            @(negedge clk);
            lk_pc = 32'(i << 2);
            #1;
            check("R1", int'(lk_taken), 0);
        end
        check("R1", int'(lk_hist), 0);

        // R3: saturate high at hist 2, then one step down stays taken
        for (int i = 0; i < 5; i++) cycle(32'h0, 1'b1, 32'h44, 1'b1, 2, "R3");
        cycle(32'h0, 1'b1, 32'h44, 1'b0, 2, "R3");
        set_hist(2);
        probe(32'h44, "R3", 1);

        // R4: saturate low at hist 1, then one step up stays not taken
        for (int i = 0; i < 4; i++) cycle(32'h0, 1'b1, 32'h4C, 1'b0, 1, "R4");
        cycle(32'h0, 1'b1, 32'h4C, 1'b1, 1, "R4");
        set_hist(1);
        probe(32'h4C, "R4", 0);

        // R6: train with a snapshot that differs from the live history
        set_hist(0);
        cycle(32'h0, 1'b1, 32'h50, 1'b1, 3, "R6");
        cycle(32'h0, 1'b1, 32'h50, 1'b1, 3, "R6");
        set_hist(3);
        probe(32'h50, "R6", 1);
        set_hist(0);
        probe(32'h50, "R6", 0);

        // R9: hist 3 counter of row 5 trained, hist 0 counter untouched
        cycle(32'h0, 1'b1, 32'h54, 1'b1, 3, "R9");
        cycle(32'h0, 1'b1, 32'h54, 1'b1, 3, "R9");
        set_hist(3);
        probe(32'h54, "R9", 1);
        set_hist(0);
        probe(32'h54, "R9", 0);

        // R7: low two bits and bits above the row field are ignored
        set_hist(3);
        probe(32'h57, "R7", 1);
        probe(32'h0001_0054, "R7", 1);
        probe(32'h94, "R7", 1);

        // R8: same-cycle lookup and update of a weak not-taken counter
        set_hist(2);
        cycle(32'h58, 1'b1, 32'h58, 1'b1, 2, "R8");
        check("R8", mdl[midx(32'h58, 2)], 2);

        // R2: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] lp;
            logic [31:0] upc;
            lp  = ($urandom & 32'h0000_00FF) | (($urandom & 32'h3) << 20);
            upc = ($urandom % 3 == 0) ? lp : ($urandom & 32'h0000_00FF);
            cycle(lp, bit'($urandom % 4 != 0), upc, bit'($urandom & 1),
                  (($urandom % 2) == 0) ? mhist : int'($urandom % (1 << M)), "R2");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule